// File: doc/BRIEF.md
# Command Packet Responder

This block sits behind a byte-serial handshake engine. Once the host has finished sending a packet to the device, the engine forwards that packet as a byte stream. The first byte is the packet type. For pseudo-command packets, the second byte is the command code and the third byte is an optional argument. The block decodes the packet and builds a framed reply. The reply always begins with the pseudo-command type byte. It is streamed back one byte per handshake, for the engine to load into its host-bound buffer.

The block also keeps two timers:
- A free-running seconds counter on the 1904 epoch, which the get-time reply returns big-endian.
- A periodic poll tick that the autopoll command turns on or off.

A power-down command is acknowledged first. Once the acknowledgement has left the block, a sticky shutdown request is raised. Any packet the block does not understand is dropped silently.

Both streams use valid/ready. On the input side, a byte moves on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so a new packet is held off until the previous reply has been taken completely. On the output side, once `out_valid` rises it stays high, and `out_data`, `out_last` and `out_len` stay unchanged, until `out_ready` accepts the byte. The consumer may stall for any number of cycles.

Top module: `pkt_responder`

## Requirements
- R1: `in_ready` is high only while no reply is pending or being streamed. Input bytes are never accepted while `out_valid` is high or while the last packet is being decoded.
- R2: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_len` hold their values. Each handshake transfers one byte. `out_last` marks the final byte. `out_len` gives the total reply length (2 or 7) on every beat.
- R3: The first byte of every reply is 0x01, the pseudo-command type.
- R4: A pseudo-command (type byte 0x01) with code 0x09, 0x13, 0x14, 0x19 or 0x21 gets the reply {0x01, 0x00}. Extra payload bytes are ignored.
- R5: Code 0x03 (get time) gets a 7-byte reply: 0x01, 0x00, 0x00, and then the 32-bit seconds value from the most significant byte to the least significant byte.
- R6: The seconds value is BOOT_SECONDS + 2,082,844,800 at reset. It then rises by one every CLK_HZ clock cycles. The reply carries the value sampled in the cycle after the packet's last byte was accepted.
- R7: Code 0x01 (autopoll) with an argument byte gets the reply {0x01, argument}. A nonzero argument turns the poll tick on, and zero turns it off.
- R8: While polling is on, `poll_tick` pulses for one cycle every CLK_HZ/POLL_HZ cycles. While polling is off, it stays low.
- R9: An autopoll command that does not change the on/off state leaves the tick phase unchanged.
- R10: Code 0x0A (power down) gets the reply {0x01, 0x00}. `shutdown_req` rises in the cycle after the last reply byte is handed off and stays high until reset.
- R11: The block drops a packet without a reply and without any state change in these cases:
  - the type byte is not 0x01;
  - the code is not one listed above;
  - the packet is shorter than 2 bytes;
  - it is an autopoll packet shorter than 3 bytes.

  After such a packet, `in_ready` returns high.
- R12: During and after reset, `in_ready` is 1 and `out_valid`, `poll_tick` and `shutdown_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input packet byte |
| in_last | input | 1 | Final byte of the input packet |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Consumer accepts the reply byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| out_len | output | 3 | Total reply length in bytes |
| poll_tick | output | 1 | One-cycle periodic poll pulse |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
The assertions assume the following about the block's environment:
- The poll period CLK_HZ/POLL_HZ is at least two cycles, which the single-cycle-pulse property relies on.
- The input side keeps `in_last` meaningful on every accepted byte.
- `out_ready` may take any value in any cycle.

The stimulus keeps to these assumptions in three ways. It builds the block with a 40-cycle poll period. It drives packets only through a task that sets a proper `in_last`. It draws `out_ready` at random on every cycle, so the reply-hold rule is exercised under stalls.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam logic [7:0] TYP_PSEUDO    = 8'h01;
  localparam logic [7:0] CMD_AUTOPOLL  = 8'h01;
  localparam logic [7:0] CMD_GET_TIME  = 8'h03;
  localparam logic [7:0] CMD_SET_TIME  = 8'h09;
  localparam logic [7:0] CMD_POWER_OFF = 8'h0A;
  localparam logic [7:0] CMD_FS_FLAG   = 8'h13;
  localparam logic [7:0] CMD_AUTO_RATE = 8'h14;
  localparam logic [7:0] CMD_DEV_LIST  = 8'h19;
  localparam logic [7:0] CMD_PWR_MSG   = 8'h21;

  localparam logic [31:0] EPOCH_GAP = 32'd2082844800;

  localparam int RESP_SHORT = 2;
  localparam int RESP_TIME  = 7;
  localparam int LEN_W      = $clog2(RESP_TIME + 1);

  typedef enum logic [1:0] {ST_RX, ST_DEC, ST_TX} fsm_t;
  typedef enum logic [1:0] {RK_NONE, RK_ACK, RK_TIME, RK_POLL} rkind_t;
endpackage

// File: rtl/prs_sec_count.sv
module prs_sec_count #(
  parameter int          CLK_HZ = 50_000_000,
  parameter logic [31:0] INIT   = 32'd0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] sec
);
  localparam int PW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      sec <= INIT;
    end else if (pre == PW'(CLK_HZ - 1)) begin
      pre <= '0;
      sec <= sec + 32'd1;
    end else begin
      pre <= pre + PW'(1);
    end
  end

  // R6: the seconds value only ever holds or steps by one
  a_r6_sec_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sec == $past(sec)) || (sec == $past(sec) + 32'd1));
endmodule

// File: rtl/prs_poll_timer.sv
module prs_poll_timer #(
  parameter int PERIOD = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic cmd_on,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic          en;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (cmd && (cmd_on != en)) begin
        en  <= cmd_on;
        cnt <= '0;
      end else if (en) begin
        if (cnt == CW'(PERIOD - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  a_r8_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r8_tick_enabled: assert property (@(posedge clk) disable iff (rst)
    tick |-> en);
endmodule

// File: rtl/prs_cmd_engine.sv
module prs_cmd_engine
  import prs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  input  logic [31:0]      sec_now,
  output logic             ap_cmd,
  output logic             ap_on,
  output logic             shutdown_req
);
  fsm_t             st;
  logic [1:0]       rx_cnt;
  logic [7:0]       b_type, b_code, b_arg;
  logic [LEN_W-1:0] rlen, idx;
  logic [7:0]       r_b1;
  logic [31:0]      snap;
  logic             pwr_pend;
  rkind_t           dk;
  logic             dpwr;

  // decode of the captured header bytes
  always_comb begin
    dk   = RK_NONE;
    dpwr = 1'b0;
    if (b_type == TYP_PSEUDO && rx_cnt >= 2'd2) begin
      case (b_code)
        CMD_AUTOPOLL:  if (rx_cnt == 2'd3) dk = RK_POLL;
        CMD_GET_TIME:  dk = RK_TIME;
        CMD_SET_TIME, CMD_FS_FLAG, CMD_AUTO_RATE,
        CMD_DEV_LIST, CMD_PWR_MSG: dk = RK_ACK;
        CMD_POWER_OFF: begin dk = RK_ACK; dpwr = 1'b1; end
        default:       dk = RK_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RX;
      rx_cnt       <= '0;
      b_type       <= '0;
      b_code       <= '0;
      b_arg        <= '0;
      rlen         <= LEN_W'(RESP_SHORT);
      idx          <= '0;
      r_b1         <= '0;
      snap         <= '0;
      pwr_pend     <= 1'b0;
      ap_cmd       <= 1'b0;
      ap_on        <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      ap_cmd <= 1'b0;
      case (st)
        ST_RX: if (in_valid) begin
          case (rx_cnt)
            2'd0:    b_type <= in_data;
            2'd1:    b_code <= in_data;
            2'd2:    b_arg  <= in_data;
            default: ;
          endcase
          if (rx_cnt != 2'd3) rx_cnt <= rx_cnt + 2'd1;
          if (in_last) st <= ST_DEC;
        end
        ST_DEC: begin
          rx_cnt <= '0;
          if (dk == RK_NONE) begin
            st <= ST_RX;
          end else begin
            st       <= ST_TX;
            idx      <= '0;
            rlen     <= (dk == RK_TIME) ? LEN_W'(RESP_TIME) : LEN_W'(RESP_SHORT);
            r_b1     <= (dk == RK_POLL) ? b_arg : 8'h00;
            snap     <= sec_now;
            pwr_pend <= dpwr;
            if (dk == RK_POLL) begin
              ap_cmd <= 1'b1;
              ap_on  <= (b_arg != 8'h00);
            end
          end
        end
        ST_TX: if (out_ready) begin
          if (out_last) begin
            st <= ST_RX;
            if (pwr_pend) shutdown_req <= 1'b1;
          end else begin
            idx <= idx + LEN_W'(1);
          end
        end
        default: st <= ST_RX;
      endcase
    end
  end

  assign in_ready  = (st == ST_RX);
  assign out_valid = (st == ST_TX);
  assign out_last  = out_valid && (idx == rlen - LEN_W'(1));
  assign out_len   = rlen;

  always_comb begin
    case (idx)
      LEN_W'(0): out_data = TYP_PSEUDO;
      LEN_W'(1): out_data = r_b1;
      LEN_W'(3): out_data = snap[31:24];
      LEN_W'(4): out_data = snap[23:16];
      LEN_W'(5): out_data = snap[15:8];
      LEN_W'(6): out_data = snap[7:0];
      default:   out_data = 8'h00;
    endcase
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_last) && $stable(out_len));
  a_r2_len_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == LEN_W'(RESP_SHORT) || out_len == LEN_W'(RESP_TIME)));
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> shutdown_req);
endmodule

// File: rtl/pkt_responder.sv
module pkt_responder
  import prs_pkg::*;
#(
  parameter int          CLK_HZ       = 50_000_000,
  parameter int          POLL_HZ      = 50,
  parameter logic [31:0] BOOT_SECONDS = 32'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  output logic             poll_tick,
  output logic             shutdown_req
);
  localparam int          POLL_PERIOD = CLK_HZ / POLL_HZ;
  localparam logic [31:0] SEC_INIT    = BOOT_SECONDS + EPOCH_GAP;

  logic [31:0] sec_now;
  logic        ap_cmd, ap_on;

  prs_sec_count #(.CLK_HZ(CLK_HZ), .INIT(SEC_INIT)) u_sec (
    .clk(clk), .rst(rst), .sec(sec_now)
  );

  prs_poll_timer #(.PERIOD(POLL_PERIOD)) u_poll (
    .clk(clk), .rst(rst), .cmd(ap_cmd), .cmd_on(ap_on), .tick(poll_tick)
  );

  prs_cmd_engine u_eng (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_len(out_len),
    .sec_now(sec_now), .ap_cmd(ap_cmd), .ap_on(ap_on),
    .shutdown_req(shutdown_req)
  );

  a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);
endmodule

// File: tb/tb_pkt_responder.sv
module tb_pkt_responder;
  localparam int          HZ   = 2000;
  localparam int          PHZ  = 50;
  localparam int          PER  = HZ / PHZ;
  localparam logic [31:0] BOOT = 32'd1000000000;
  localparam longint      SEC0 = longint'(BOOT) + 64'd2082844800;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last, poll_tick, shutdown_req;
  logic [7:0] out_data;
  logic [2:0] out_len;

  pkt_responder #(.CLK_HZ(HZ), .POLL_HZ(PHZ), .BOOT_SECONDS(BOOT)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_len(out_len), .poll_tick(poll_tick), .shutdown_req(shutdown_req)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int wd = 0;
  int total = 0, fails = 0;

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 180000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<180000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int model(input logic [7:0] t, c, a, input int n,
                               output logic [7:0] r [8]);
    for (int i = 0; i < 8; i++) r[i] = 8'h00;
    r[0] = 8'h01;
    if (t != 8'h01 || n < 2) return 0;
    case (c)
      8'h01: begin if (n < 3) return 0; r[1] = a; return 2; end
      8'h03: return 7;
      8'h09, 8'h13, 8'h14, 8'h19, 8'h21, 8'h0A: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic send_pkt(input logic [7:0] p [8], input int n, output int e);
    e = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_data = p[i]; in_valid = 1'b1; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 e = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic recv(output logic [7:0] g [8], output int n, output int lenv);
    bit first = 1'b1;
    n = 0; lenv = 0;
    for (int i = 0; i < 8; i++) g[i] = 8'h00;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && first) begin
        chk(!in_ready, "R1 in_ready during reply", in_ready, 0);
        first = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (n < 8) g[n] = out_data;
        lenv = out_len;
        n++;
        if (out_last) break;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run(input logic [7:0] t, c, a, input int n, input string tag);
    logic [7:0] p [8];
    logic [7:0] r [8];
    logic [7:0] g [8];
    int e, el, gn, lenv;
    p[0] = t; p[1] = c; p[2] = a;
    for (int i = 3; i < 8; i++) p[i] = 8'($urandom);
    send_pkt(p, n, e);
    el = model(t, c, a, n, r);
    if (el == 0) begin
      bit seen = 1'b0;
      repeat (12) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      chk(!seen, {"R11 no reply ", tag}, seen, 0);
      chk(in_ready, {"R11 ready again ", tag}, in_ready, 1);
    end else begin
      recv(g, gn, lenv);
      chk(gn == el, {"R2 beat count ", tag}, gn, el);
      chk(lenv == el, {"R2 out_len ", tag}, lenv, el);
      chk(g[0] == 8'h01, "R3 lead byte", g[0], 8'h01);
      for (int i = 1; i < el && i < 3; i++)
        chk(g[i] == r[i], {"byte ", tag}, g[i], r[i]);
      if (el == 7) begin
        longint v, lo, hi;
        v  = {g[3], g[4], g[5], g[6]};
        lo = SEC0 + (e - 1) / HZ;
        hi = SEC0 + (e + 1) / HZ;
        chk(v >= lo && v <= hi, "R6 seconds value", v, lo);
      end
    end
  endtask

  task automatic wait_tick(output int t);
    t = -1;
    for (int k = 0; k < 4 * PER; k++) begin
      @(negedge clk);
      if (poll_tick) begin t = cyc; break; end
    end
    chk(t >= 0, "R8 tick seen", t, 0);
  endtask

  task automatic no_tick(input int len, input string tag);
    bit seen = 1'b0;
    repeat (len) begin
      @(negedge clk);
      if (poll_tick) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    int t0, t1, t2;
    logic [7:0] acks [5] = '{8'h09, 8'h13, 8'h14, 8'h19, 8'h21};
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R12 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
    chk(poll_tick == 1'b0, "R12 poll_tick", poll_tick, 0);
    chk(shutdown_req == 1'b0, "R12 shutdown", shutdown_req, 0);
    rst = 1'b0;

    run(8'h01, 8'h03, 8'h00, 2, "R5 get time");
    foreach (acks[i]) run(8'h01, acks[i], 8'h00, 2 + i, "R4 ack");

    run(8'h01, 8'h01, 8'h00, 3, "R7 autopoll off");
    no_tick(3 * PER, "R8 no tick while off");
    run(8'h01, 8'h01, 8'h05, 3, "R7 autopoll on");
    wait_tick(t0);
    wait_tick(t1);
    chk(t1 - t0 == PER, "R8 tick period", t1 - t0, PER);
    run(8'h01, 8'h01, 8'h80, 4, "R7 autopoll repeat");
    wait_tick(t2);
    chk((t2 - t0) % PER == 0, "R9 phase kept", (t2 - t0) % PER, 0);
    run(8'h01, 8'h01, 8'h00, 3, "R7 autopoll off again");
    no_tick(3 * PER, "R8 stopped");

    run(8'h01, 8'h55, 8'h00, 2, "unknown code");
    run(8'h00, 8'h01, 8'h01, 3, "type 0");
    run(8'h02, 8'h03, 8'h00, 2, "type 2");
    run(8'h01, 8'h01, 8'h01, 2, "short autopoll");
    no_tick(3 * PER, "R11 short autopoll left poll off");
    run(8'h01, 8'h03, 8'h00, 1, "one byte");

    repeat (2100) @(negedge clk);
    run(8'h01, 8'h03, 8'h00, 3, "R5 get time later");

    chk(shutdown_req == 1'b0, "R10 before power-down", shutdown_req, 0);
    run(8'h01, 8'h0A, 8'h00, 2, "R10 power down");
    chk(shutdown_req == 1'b1, "R10 shutdown raised", shutdown_req, 1);

    for (int k = 0; k < 60; k++) begin
      int sel = $urandom % 6;
      logic [7:0] t = 8'h01, c, a = 8'($urandom);
      int n = 2 + ($urandom % 5);
      case (sel)
        0: c = acks[$urandom % 5];
        1: c = 8'h03;
        2: c = 8'h01;
        3: c = 8'h0A;
        4: c = 8'h40 + 8'($urandom % 16);
        default: begin t = 8'h02 + 8'($urandom % 5); c = 8'h03; end
      endcase
      if ($urandom % 8 == 0) n = 1 + ($urandom % 2);
      run(t, c, a, n, "random");
    end
    chk(shutdown_req == 1'b1, "R10 shutdown held", shutdown_req, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule